// File: doc/BRIEF.md
# Overtemperature Assertion Duration Timer

This block measures how long an active-low overtemperature input stays low. It adds up that time in an 8-bit timer register and compares it with a programmable limit. The input is expected to arrive already synchronized to the block clock. An internal prescaler divides the system clock into units of 22.76 ms; the division ratio is a parameter, so a testbench can shorten the unit. The accumulated total is kept across separate assertions until software reads the register.

Bits [7:1] of the timer hold the count in units and stop at all ones. A read clears the register. A read taken while the input is still low leaves bit 0 set, which flags an assertion still in progress, and counting then restarts from zero. The limit selects one of five thresholds that double at each step: 22.76, 45.52, 91.04, 182.08 or 364.16 ms. Reaching the selected threshold sets a sticky status bit. The interrupt request is that status bit gated by a mask bit.

Top module: `ot_dur_timer`

## Requirements
- R1: After reset the timer output is 0x00, the limit status is 0 and the interrupt request is 0. The limit configuration resets to select 4 with the mask bit 0.
- R2: Timer bits [7:1] increase by one for every TICKS_PER_LSB clock cycles in which ot_n_i is low. Cycles with ot_n_i high hold both the count and the partial progress, so time from separate assertions adds up.
- R3: Timer bits [7:1] saturate at 127 and do not wrap while the input stays low.
- R4: A timer read strobe taken while ot_n_i is high makes all 8 timer bits 0 from the next cycle.
- R5: A timer read strobe taken while ot_n_i is low makes the timer 0x01 in the next cycle and discards partial progress. Bits [7:1] then reach 1 after another TICKS_PER_LSB low cycles.
- R6: Bit 0 keeps its value until the next timer read. A read with the input high clears it; a read with the input low sets it.
- R7: A limit write loads lim_wdata_i[2:0] as the step select and lim_wdata_i[3] as the mask. Select k from 0 to 4 gives a threshold of 2^k units. The limit status is set in the cycle after timer bits [7:1] first reach or exceed that threshold. Selects 5 to 7 disable the comparison.
- R8: The limit status is sticky. A status read strobe clears it only when the threshold condition is false in that cycle. A status read while the condition holds leaves it set, and clearing the timer alone does not clear it.
- R9: irq_o is high exactly when the limit status is 1 and the mask bit is 0. A change to the mask is seen on irq_o in the cycle after the write.
- R10: Bit 0 plays no part in the limit comparison. With select 0, a timer of 0x01 does not set the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ot_n_i | input | 1 | Synchronized overtemperature input, active low |
| tmr_rd_i | input | 1 | One-cycle strobe: timer register read |
| sts_rd_i | input | 1 | One-cycle strobe: limit status read |
| lim_wr_i | input | 1 | One-cycle strobe: write limit configuration |
| lim_wdata_i | input | 4 | [3] interrupt mask, [2:0] threshold step select |
| tmr_o | output | TMR_W (8) | Timer register: [7:1] units, [0] assertion-in-progress flag |
| lim_sts_o | output | 1 | Sticky limit-reached status |
| irq_o | output | 1 | Interrupt request: status and not mask |

## Verification
A prescaler that drifts, or fails to hold its count over gaps, shows on tmr_o. Bits [7:1] step one cycle early or late at the first unit boundary after the fault, so the bench runs assertions split by idle gaps. A wrong flag or clear decision shows on tmr_o in the cycle right after the read strobe. A wrong threshold decode or a lost sticky bit shows on lim_sts_o and irq_o one cycle after timer bits [7:1] cross the selected step, or in the cycle after a status read. A bench model compared on every clock therefore catches each fault within a single unit period.

// File: rtl/ot_dur_pkg.sv
package ot_dur_pkg;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned NUM_STEPS = 5;

  typedef struct packed {
    logic             mask;
    logic [SEL_W-1:0] sel;
  } lim_cfg_t;
endpackage

// File: rtl/ot_dur_prescale.sv
module ot_dur_prescale #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign tick_o  = run_i & at_last & ~clr_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (run_i) begin
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ot_dur_accum.sv
module ot_dur_accum #(
  parameter int unsigned TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             busy_i,
  input  logic             rd_i,
  output logic [TMR_W-2:0] units_o,
  output logic             flag_o
);
  localparam int unsigned UW = TMR_W - 1;
  localparam logic [UW-1:0] FULL = {UW{1'b1}};

  logic [UW-1:0] units_q, units_d;
  logic          flag_q, flag_d;

  always_comb begin
    units_d = units_q;
    flag_d  = flag_q;
    if (rd_i) begin
      units_d = '0;
      flag_d  = busy_i;
    end else if (tick_i && (units_q != FULL)) begin
      units_d = units_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      units_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      units_q <= units_d;
      flag_q  <= flag_d;
    end
  end

  assign units_o = units_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/ot_dur_limit.sv
module ot_dur_limit
  import ot_dur_pkg::*;
#(
  parameter int unsigned UW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [UW-1:0] units_i,
  input  logic          wr_i,
  input  lim_cfg_t      wcfg_i,
  input  logic          sts_rd_i,
  output logic          sts_o,
  output logic          irq_o
);
  localparam lim_cfg_t CFG_RST = '{mask: 1'b0, sel: SEL_W'(NUM_STEPS - 1)};

  lim_cfg_t               cfg_q, cfg_d;
  logic                   sts_q, sts_d;
  logic [NUM_STEPS-1:0]   step_hit;
  logic                   reached;

  for (genvar k = 0; k < NUM_STEPS; k++) begin : g_step
    assign step_hit[k] = |units_i[UW-1:k];
  end

  always_comb begin
    reached = 1'b0;
    for (int k = 0; k < NUM_STEPS; k++) begin
      if (cfg_q.sel == SEL_W'(k)) reached = step_hit[k];
    end
  end

  always_comb begin
    cfg_d = wr_i ? wcfg_i : cfg_q;
    sts_d = reached | (sts_q & ~sts_rd_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
      sts_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      sts_q <= sts_d;
    end
  end

  assign sts_o = sts_q;
  assign irq_o = sts_q & ~cfg_q.mask;
endmodule

// File: rtl/ot_dur_timer.sv
module ot_dur_timer
  import ot_dur_pkg::*;
#(
  parameter int unsigned TMR_W         = 8,
  parameter int unsigned TICKS_PER_LSB = 1138000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ot_n_i,
  input  logic             tmr_rd_i,
  input  logic             sts_rd_i,
  input  logic             lim_wr_i,
  input  logic [SEL_W:0]   lim_wdata_i,
  output logic [TMR_W-1:0] tmr_o,
  output logic             lim_sts_o,
  output logic             irq_o
);
  localparam int unsigned UW = TMR_W - 1;

  logic          busy;
  logic          tick;
  logic [UW-1:0] units;
  logic          flag;
  lim_cfg_t      wcfg;

  assign busy = ~ot_n_i;
  assign wcfg = lim_wdata_i;

  ot_dur_prescale #(.DIV(TICKS_PER_LSB)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (busy),
    .clr_i  (tmr_rd_i),
    .tick_o (tick)
  );

  ot_dur_accum #(.TMR_W(TMR_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick),
    .busy_i  (busy),
    .rd_i    (tmr_rd_i),
    .units_o (units),
    .flag_o  (flag)
  );

  ot_dur_limit #(.UW(UW)) u_lim (
    .clk      (clk),
    .rst_n    (rst_n),
    .units_i  (units),
    .wr_i     (lim_wr_i),
    .wcfg_i   (wcfg),
    .sts_rd_i (sts_rd_i),
    .sts_o    (lim_sts_o),
    .irq_o    (irq_o)
  );

  assign tmr_o = {units, flag};
endmodule

// File: rtl/ot_dur_chk.sv
module ot_dur_chk #(
  parameter int unsigned TMR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ot_n_i,
  input logic             tmr_rd_i,
  input logic             sts_rd_i,
  input logic [TMR_W-1:0] tmr_o,
  input logic             lim_sts_o,
  input logic             irq_o
);
  a_r4_idle_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_rd_i && ot_n_i) |=> (tmr_o == '0));

  a_r5_busy_read_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_rd_i && !ot_n_i) |=> (tmr_o == TMR_W'(1)));

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_rd_i && ot_n_i) |=> $stable(tmr_o));

  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_rd_i |=> ((tmr_o[TMR_W-1:1] == $past(tmr_o[TMR_W-1:1])) ||
                   (tmr_o[TMR_W-1:1] == $past(tmr_o[TMR_W-1:1]) + 1'b1)));

  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_rd_i && (&tmr_o[TMR_W-1:1])) |=> (&tmr_o[TMR_W-1:1]));

  a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_rd_i |=> (tmr_o[0] == $past(tmr_o[0])));

  a_r8_clear_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lim_sts_o) |-> $past(sts_rd_i));

  a_r9_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> lim_sts_o);
endmodule

bind ot_dur_timer ot_dur_chk #(.TMR_W(TMR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ot_n_i    (ot_n_i),
  .tmr_rd_i  (tmr_rd_i),
  .sts_rd_i  (sts_rd_i),
  .tmr_o     (tmr_o),
  .lim_sts_o (lim_sts_o),
  .irq_o     (irq_o)
);

// File: tb/ot_dur_timer_tb_top.sv
module ot_dur_timer_tb_top;
  localparam int TW = 8;
  localparam int NT = 4;
  localparam int MAXU = 127;

  logic          clk;
  logic          rst_n;
  logic          ot_n, tmr_rd, sts_rd, lim_wr;
  logic [3:0]    lim_wdata;
  logic [TW-1:0] tmr;
  logic          sts, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  string phase = "R1";

  // reference model state
  int m_elapsed, m_sel;
  bit m_flag, m_sts, m_mask;

  ot_dur_timer #(.TMR_W(TW), .TICKS_PER_LSB(NT)) dut_i (
    .clk(clk), .rst_n(rst_n), .ot_n_i(ot_n), .tmr_rd_i(tmr_rd),
    .sts_rd_i(sts_rd), .lim_wr_i(lim_wr), .lim_wdata_i(lim_wdata),
    .tmr_o(tmr), .lim_sts_o(sts), .irq_o(irq)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic int m_units();
    int u = m_elapsed / NT;
    return (u > MAXU) ? MAXU : u;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_elapsed = 0; m_flag = 0; m_sts = 0; m_sel = 4; m_mask = 0;
    end else begin
      bit hit;
      hit = (m_sel <= 4) && (m_units() >= (1 << m_sel));
      m_sts = hit || (m_sts && !sts_rd);
      if (lim_wr) begin
        m_sel = int'(lim_wdata[2:0]);
        m_mask = lim_wdata[3];
      end
      if (tmr_rd) begin
        m_elapsed = 0;
        m_flag = !ot_n;
      end else if (!ot_n && m_elapsed < (MAXU + 1) * NT) begin
        m_elapsed = m_elapsed + 1;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({phase, " model tmr"}, int'(tmr), (m_units() << 1) | int'(m_flag));
      check({phase, " model sts"}, int'(sts), int'(m_sts));
      check({phase, " model irq"}, int'(irq), int'(m_sts && !m_mask));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tmr_rd();
    tmr_rd = 1; cyc(1); tmr_rd = 0;
  endtask

  task automatic pulse_sts_rd();
    sts_rd = 1; cyc(1); sts_rd = 0;
  endtask

  task automatic write_lim(logic [3:0] v);
    lim_wdata = v; lim_wr = 1; cyc(1); lim_wr = 0;
  endtask

  initial begin
    rst_n = 0; ot_n = 1; tmr_rd = 0; sts_rd = 0; lim_wr = 0; lim_wdata = '0;
    cyc(3);
    rst_n = 1;
    cyc(2);
    check("R1 reset tmr", int'(tmr), 0);
    check("R1 reset sts", int'(sts), 0);
    check("R1 reset irq", int'(irq), 0);

    phase = "R2";
    ot_n = 0; cyc(6); ot_n = 1; cyc(5); ot_n = 0; cyc(2); ot_n = 1;
    check("R2 split accumulation", int'(tmr), 8'h04);

    phase = "R4";
    pulse_tmr_rd();
    check("R4 idle read clears", int'(tmr), 8'h00);

    phase = "R5";
    ot_n = 0; cyc(5);
    check("R5 before read", int'(tmr), 8'h02);
    pulse_tmr_rd();
    check("R5 busy read gives 01", int'(tmr), 8'h01);
    cyc(4);
    check("R5 counting resumes", int'(tmr), 8'h03);
    phase = "R6";
    ot_n = 1; cyc(3);
    check("R6 flag held", int'(tmr), 8'h03);
    pulse_tmr_rd();
    check("R6 idle read clears flag", int'(tmr), 8'h00);

    phase = "R7";
    write_lim(4'b0001);
    ot_n = 0; cyc(8);
    check("R7 units at threshold", int'(tmr), 8'h04);
    check("R7 status one cycle later", int'(sts), 0);
    ot_n = 1; cyc(1);
    check("R7 status set", int'(sts), 1);
    check("R9 irq unmasked", int'(irq), 1);

    phase = "R8";
    pulse_sts_rd();
    check("R8 read while condition holds", int'(sts), 1);
    pulse_tmr_rd();
    check("R8 timer clear keeps status", int'(sts), 1);
    pulse_sts_rd();
    check("R8 read clears status", int'(sts), 0);
    check("R8 irq follows", int'(irq), 0);

    phase = "R9";
    ot_n = 0; cyc(8); ot_n = 1; cyc(1);
    check("R9 irq before mask", int'(irq), 1);
    write_lim(4'b1001);
    check("R9 masked irq", int'(irq), 0);
    check("R9 status kept under mask", int'(sts), 1);
    pulse_tmr_rd();
    pulse_sts_rd();

    phase = "R10";
    write_lim(4'b0000);
    ot_n = 0; cyc(2);
    pulse_tmr_rd();
    ot_n = 1; cyc(3);
    check("R10 flag only", int'(tmr), 8'h01);
    check("R10 flag ignored by compare", int'(sts), 0);
    pulse_tmr_rd();

    phase = "R3";
    write_lim(4'b0111);
    ot_n = 0; cyc(MAXU * NT + 20);
    check("R3 saturated", int'(tmr), 8'hFE);
    check("R7 disabled select", int'(sts), 0);
    ot_n = 1; cyc(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule